// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a configuration access window that occupies two adjacent addresses on a byte-wide I/O bus. The lower address is the index port and the next address up is the data port. After reset the window is closed. Software opens it by writing the unlock key twice in a row to the index port. While the window is open, a byte written to the index port chooses a configuration register. Reads and writes at the data port then reach that register. Writing the lock key to the index port closes the window again.

A small set of global registers is always visible while the window is open. It holds a vendor identifier, a device identifier, a revision byte and a logical-device selector. Register indices from 0x30 upward are per-device. The same index reaches a different bank depending on the selector value, and each bank holds an enable flag and a 16-bit base address. The enable flag and the base address of every bank drive output pins so that the logical devices can use them. The logical devices themselves sit outside this block.

Top module: `cfg_keyed_port`

## Requirements
- R1: After reset the window is closed (`cfg_mode` low), the selector and the index are 0x00, every bank's enable and base are zero, and a read at the index port returns 0xFF.
- R2: Two consecutive writes of 0x87 to the index port open the window. `cfg_mode` is high from the cycle that follows the second write.
- R3: Between the two unlock writes, any other write at the index port or the data port discards the first key, so a following single 0x87 does not open the window.
- R4: While the window is closed, data-port reads return 0xFF and data-port writes change no register. An index-port write other than 0x87 does not alter the index.
- R5: With the window open, writing 0xAA to the index port closes it from the next cycle and leaves the stored index unchanged. Reopening the window shows the same index again.
- R6: With the window open, any other byte written to the index port becomes the index, and an index-port read returns it.
- R7: With the window open, data reads return the device ID high byte at index 0x20, the device ID low byte at 0x21, the revision at 0x22, and the vendor ID 0x1934 at 0x23 (0x19) and 0x24 (0x34). Writes to these indices are ignored.
- R8: Index 0x07 holds the selector, which can be read and written. Indices 0x30 and above reach the bank whose number equals the selector. If the selector is not below the bank count, those indices read 0x00 and ignore writes.
- R9: In the selected bank, index 0x30 bit 0 is the enable (bits 7:1 read as 0). Index 0x60 is the high byte and 0x61 the low byte of the base address. Bank n drives `dev_enable[n]` and `dev_base[16n+15:16n]`.
- R10: With the window open, data reads at any index not listed above return 0x00.
- R11: A read and a write at the data port in the same cycle return the value held before the write. The written value is visible from the next cycle.
- R12: Bus accesses at addresses outside the port pair read 0x00 and have no effect, including on a partially received unlock key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | I/O bus address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational in the cycle of the read |
| cfg_mode | output | 1 | High while the window is open |
| dev_enable | output | NUM_DEV | Enable flag per bank |
| dev_base | output | 16*NUM_DEV | Base address per bank, bank n at bits 16n+15:16n |

## Verification
The data-port read path and the register write path can act in the same cycle when the bus raises both strobes at the data address. The bench provokes this on a bank base byte. It expects the old byte in that read, and the new byte in a plain read one cycle later. The other meeting point is the key detector against stray writes. The bench places a data-port write, an index write and a foreign-address write between two key bytes, and judges each case by `cfg_mode` and by a later read through the window.

// File: rtl/cfgport_pkg.sv
// Package: shared constants for the keyed configuration port.
// Holds key bytes and the register indices whose values the
// software-visible behaviour depends on.
package cfgport_pkg;
    typedef logic [7:0] byte_t;

    localparam byte_t KEY_OPEN     = 8'h87;
    localparam byte_t KEY_CLOSE    = 8'hAA;

    localparam byte_t IX_SELECT    = 8'h07;
    localparam byte_t IX_DEVID_HI  = 8'h20;
    localparam byte_t IX_DEVID_LO  = 8'h21;
    localparam byte_t IX_REVISION  = 8'h22;
    localparam byte_t IX_VENDOR_HI = 8'h23;
    localparam byte_t IX_VENDOR_LO = 8'h24;
    localparam byte_t IX_BANK_LOW  = 8'h30;
    localparam byte_t IX_ENABLE    = 8'h30;
    localparam byte_t IX_BASE_HI   = 8'h60;
    localparam byte_t IX_BASE_LO   = 8'h61;
endpackage

// File: rtl/cfgp_key_gate.sv
// Module: cfgp_key_gate
// Tracks whether the configuration window is open. The window opens on two
// back-to-back open-key writes at the index port and closes on a close-key
// write. Assumes port_wr covers writes at either port address and idx_wr
// is the subset aimed at the index port.
module cfgp_key_gate
    import cfgport_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  port_wr,
    input  logic  idx_wr,
    input  byte_t wdata,
    output logic  open_q
);
    logic armed_q;

    // Purpose: key sequence detector and window state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (!open_q) begin
            if (port_wr) begin
                if (idx_wr && wdata == KEY_OPEN) begin
                    if (armed_q) begin
                        open_q  <= 1'b1;
                        armed_q <= 1'b0;
                    end else begin
                        armed_q <= 1'b1;
                    end
                end else begin
                    armed_q <= 1'b0;
                end
            end
        end else if (idx_wr && wdata == KEY_CLOSE) begin
            open_q  <= 1'b0;
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgp_dev_bank.sv
// Module: cfgp_dev_bank
// One logical-device register bank: an enable flag and a 16-bit base.
// Responds only while sel is high (window open and selector matching).
// Read data is zero when not selected so banks can be OR-combined.
module cfgp_dev_bank
    import cfgport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        data_wr,
    input  byte_t       idx,
    input  byte_t       wdata,
    output logic        enable_q,
    output logic [15:0] base_q,
    output byte_t       rdata
);
    // Purpose: bank register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            base_q   <= 16'h0000;
        end else if (sel && data_wr) begin
            case (idx)
                IX_ENABLE:  enable_q      <= wdata[0];
                IX_BASE_HI: base_q[15:8]  <= wdata;
                IX_BASE_LO: base_q[7:0]   <= wdata;
                default: ;
            endcase
        end
    end

    // Purpose: bank read data
    always_comb begin
        rdata = 8'h00;
        if (sel) begin
            case (idx)
                IX_ENABLE:  rdata = {7'b0, enable_q};
                IX_BASE_HI: rdata = base_q[15:8];
                IX_BASE_LO: rdata = base_q[7:0];
                default:    rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/cfgp_read_mux.sv
// Module: cfgp_read_mux
// Chooses the byte returned to the bus: index or 0xFF at the index port,
// global or bank registers (or 0xFF while closed) at the data port,
// zero elsewhere. Purely combinational.
module cfgp_read_mux
    import cfgport_pkg::*;
#(
    parameter logic [15:0] DEVICE_ID = 16'h0A51,
    parameter logic [7:0]  REVISION  = 8'h03,
    parameter logic [15:0] VENDOR_ID = 16'h1934
) (
    input  logic  rd,
    input  logic  at_idx,
    input  logic  at_data,
    input  logic  open_q,
    input  byte_t idx,
    input  byte_t select,
    input  byte_t bank_rd,
    output byte_t rdata
);
    // Purpose: read data selection
    always_comb begin
        rdata = 8'h00;
        if (rd && at_idx) begin
            rdata = open_q ? idx : 8'hFF;
        end else if (rd && at_data) begin
            if (!open_q) begin
                rdata = 8'hFF;
            end else begin
                case (idx)
                    IX_SELECT:    rdata = select;
                    IX_DEVID_HI:  rdata = DEVICE_ID[15:8];
                    IX_DEVID_LO:  rdata = DEVICE_ID[7:0];
                    IX_REVISION:  rdata = REVISION;
                    IX_VENDOR_HI: rdata = VENDOR_ID[15:8];
                    IX_VENDOR_LO: rdata = VENDOR_ID[7:0];
                    default:      rdata = (idx >= IX_BANK_LOW) ? bank_rd : 8'h00;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_keyed_port.sv
// Module: cfg_keyed_port
// Top of the keyed index/data configuration port. Decodes the two port
// addresses, holds the index and logical-device selector, and instantiates
// one register bank per logical device. Assumes at most one bus write per
// cycle; a read may share the cycle with a write.
module cfg_keyed_port
    import cfgport_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     BASE_ADDR = 16'h002E,
    parameter int              NUM_DEV   = 4,
    parameter logic [15:0]     DEVICE_ID = 16'h0A51,
    parameter logic [7:0]      REVISION  = 8'h03,
    parameter logic [15:0]     VENDOR_ID = 16'h1934
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  cfg_mode,
    output logic [NUM_DEV-1:0]    dev_enable,
    output logic [16*NUM_DEV-1:0] dev_base
);
    localparam logic [ADDR_W-1:0] IDX_ADDR  = BASE_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DATA_ADDR = IDX_ADDR + 1'b1;

    logic  at_idx, at_data, idx_wr, data_wr, port_wr;
    byte_t idx_q, select_q, bank_rd;
    byte_t bank_rd_each [NUM_DEV];
    logic  [NUM_DEV-1:0] bank_sel;

    // Purpose: port address decode
    always_comb begin
        at_idx  = (bus_addr == IDX_ADDR);
        at_data = (bus_addr == DATA_ADDR);
        idx_wr  = bus_wr && at_idx;
        data_wr = bus_wr && at_data;
        port_wr = idx_wr || data_wr;
    end

    cfgp_key_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_wr (port_wr),
        .idx_wr  (idx_wr),
        .wdata   (bus_wdata),
        .open_q  (cfg_mode)
    );

    // Purpose: index latch and logical-device selector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= 8'h00;
            select_q <= 8'h00;
        end else if (cfg_mode) begin
            if (idx_wr && bus_wdata != KEY_CLOSE)
                idx_q <= bus_wdata;
            if (data_wr && idx_q == IX_SELECT)
                select_q <= bus_wdata;
        end
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
        assign bank_sel[g] = cfg_mode && (select_q == 8'(g));
        cfgp_dev_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (bank_sel[g]),
            .data_wr  (data_wr),
            .idx      (idx_q),
            .wdata    (bus_wdata),
            .enable_q (dev_enable[g]),
            .base_q   (dev_base[16*g +: 16]),
            .rdata    (bank_rd_each[g])
        );
    end

    // Purpose: merge bank read data (at most one bank non-zero)
    always_comb begin
        bank_rd = 8'h00;
        for (int i = 0; i < NUM_DEV; i++)
            bank_rd = bank_rd | bank_rd_each[i];
    end

    cfgp_read_mux #(
        .DEVICE_ID (DEVICE_ID),
        .REVISION  (REVISION),
        .VENDOR_ID (VENDOR_ID)
    ) u_rmux (
        .rd      (bus_rd),
        .at_idx  (at_idx),
        .at_data (at_data),
        .open_q  (cfg_mode),
        .idx     (idx_q),
        .select  (select_q),
        .bank_rd (bank_rd),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/cfg_keyed_port_chk.sv
// Module: cfg_keyed_port_chk
// Property checker for cfg_keyed_port, attached by bind. Observes the bus
// and the window state only.
module cfg_keyed_port_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h002E,
    parameter int          NUM_DEV   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic                  cfg_mode,
    input logic [NUM_DEV-1:0]    dev_enable,
    input logic [16*NUM_DEV-1:0] dev_base
);
    localparam logic [ADDR_W-1:0] IDX_ADDR  = BASE_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DATA_ADDR = IDX_ADDR + 1'b1;

    logic in_pair;
    assign in_pair = (bus_addr == IDX_ADDR) || (bus_addr == DATA_ADDR);

    assert_locked_reads_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && bus_rd && bus_addr == DATA_ADDR) |-> bus_rdata == 8'hFF);

    assert_locked_writes_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && bus_wr && bus_addr == DATA_ADDR) |=> ($stable(dev_enable) && $stable(dev_base)));

    assert_open_follows_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(bus_wr && bus_addr == IDX_ADDR && bus_wdata == 8'h87));

    assert_close_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && bus_wr && bus_addr == IDX_ADDR && bus_wdata == 8'hAA) |=> !cfg_mode);

    assert_foreign_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_pair) |-> bus_rdata == 8'h00);

    assert_mode_needs_port_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && in_pair) |=> $stable(cfg_mode));
endmodule

bind cfg_keyed_port cfg_keyed_port_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .NUM_DEV   (NUM_DEV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cfg_mode   (cfg_mode),
    .dev_enable (dev_enable),
    .dev_base   (dev_base)
);

// File: tb/cfg_keyed_port_bench.sv
// Scoreboard bench: bus tasks push expected read bytes, a negedge monitor
// pops and compares them; output pins are checked directly.
module cfg_keyed_port_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 16;
    localparam logic [15:0] BASE       = 16'h002E;
    localparam logic [15:0] DATA       = 16'h002F;
    localparam logic [15:0] OTHER      = 16'h0030;
    localparam int          NUM_DEV    = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [ADDR_W-1:0]     bus_addr = '0;
    logic                  bus_wr = 1'b0;
    logic                  bus_rd = 1'b0;
    logic [7:0]            bus_wdata = 8'h00;
    logic [7:0]            bus_rdata;
    logic                  cfg_mode;
    logic [NUM_DEV-1:0]    dev_enable;
    logic [16*NUM_DEV-1:0] dev_base;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_keyed_port #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE),
        .NUM_DEV   (NUM_DEV),
        .DEVICE_ID (16'h0A51),
        .REVISION  (8'h03),
        .VENDOR_ID (16'h1934)
    ) u_cfg_keyed_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cfg_mode   (cfg_mode),
        .dev_enable (dev_enable),
        .dev_base   (dev_base)
    );

    // Monitor: compare each read against the scoreboard head
    always @(negedge clk) begin
        if (bus_rd && !done) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard: read with no expectation, got %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: got %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic cyc(input logic wr, input logic rd, input logic [15:0] a,
                       input logic [7:0] d, input logic [7:0] e, input string t);
        @(posedge clk);
        #1;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        if (rd) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b0, a, d, 8'h00, "");
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
        cyc(1'b0, 1'b1, a, 8'h00, e, t);
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
        @(negedge clk);
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] e, input string t);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", t, act, e);
        end
    endtask

    task automatic reg_rd(input logic [7:0] ix, input logic [7:0] e, input string t);
        wr(BASE, ix);
        rd(DATA, e, t);
    endtask

    task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
        wr(BASE, ix);
        wr(DATA, d);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(64'(cfg_mode), 64'd0, "R1 cfg_mode");
        chk(64'(dev_enable), 64'd0, "R1 dev_enable");
        chk(dev_base, 64'd0, "R1 dev_base");
        rd(BASE, 8'hFF, "R1 index read locked");
        // R4: locked data read and ignored write
        rd(DATA, 8'hFF, "R4 data read locked");
        wr(DATA, 8'h55);
        wr(BASE, 8'h12);
        // R3: data write between keys breaks sequence
        wr(BASE, 8'h87); wr(DATA, 8'h00); wr(BASE, 8'h87); idle();
        chk(64'(cfg_mode), 64'd0, "R3 data write between keys");
        wr(BASE, 8'h11); wr(BASE, 8'h87); idle();
        chk(64'(cfg_mode), 64'd0, "R3 index write between keys");
        wr(BASE, 8'h22);
        // R12: foreign write between keys is ignored
        wr(BASE, 8'h87); wr(OTHER, 8'hAA); wr(BASE, 8'h87); idle();
        chk(64'(cfg_mode), 64'd1, "R12 foreign write keeps key");
        rd(OTHER, 8'h00, "R12 foreign read");
        // R4/R6: locked index writes not latched
        rd(BASE, 8'h00, "R4 index unchanged while locked");
        wr(BASE, 8'h22);
        rd(BASE, 8'h22, "R6 index readback");
        rd(DATA, 8'h03, "R7 revision");
        reg_rd(8'h20, 8'h0A, "R7 devid hi");
        reg_rd(8'h21, 8'h51, "R7 devid lo");
        reg_rd(8'h23, 8'h19, "R7 vendor hi");
        reg_rd(8'h24, 8'h34, "R7 vendor lo");
        wr(DATA, 8'h99);
        rd(DATA, 8'h34, "R7 write ignored");
        reg_rd(8'h07, 8'h00, "R4 selector untouched by locked write");
        reg_rd(8'h25, 8'h00, "R10 unimplemented 0x25");
        reg_rd(8'h40, 8'h00, "R10 unimplemented 0x40");
        // R9: bank 0
        reg_wr(8'h30, 8'hFF);
        rd(DATA, 8'h01, "R9 enable bit only");
        reg_wr(8'h60, 8'hAB);
        reg_wr(8'h61, 8'hCD);
        idle();
        chk(64'(dev_enable), 64'h1, "R9 dev_enable bank0");
        chk(dev_base, 64'h0000_0000_0000_ABCD, "R9 dev_base bank0");
        reg_rd(8'h60, 8'hAB, "R9 base hi readback");
        // R8: bank 2
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h60, 8'h00, "R8 bank2 fresh");
        reg_wr(8'h60, 8'h12);
        reg_wr(8'h30, 8'h01);
        idle();
        chk(64'(dev_enable), 64'h5, "R8 dev_enable bank2");
        chk(dev_base, 64'h0000_1200_0000_ABCD, "R8 dev_base bank2");
        // R8: out-of-range selector
        reg_wr(8'h07, 8'h09);
        reg_rd(8'h30, 8'h00, "R8 no bank read");
        wr(DATA, 8'h01);
        wr(BASE, 8'h60);
        wr(DATA, 8'h77);
        idle();
        chk(64'(dev_enable), 64'h5, "R8 no bank write enable");
        chk(dev_base, 64'h0000_1200_0000_ABCD, "R8 no bank write base");
        reg_rd(8'h07, 8'h09, "R8 selector readback");
        // R11: read and write in one cycle
        reg_wr(8'h07, 8'h00);
        wr(BASE, 8'h61);
        cyc(1'b1, 1'b1, DATA, 8'h77, 8'hCD, "R11 read returns old");
        rd(DATA, 8'h77, "R11 new value next cycle");
        // R5: close and reopen
        wr(BASE, 8'hAA); idle();
        chk(64'(cfg_mode), 64'd0, "R5 closed");
        rd(DATA, 8'hFF, "R5 data read after close");
        wr(BASE, 8'h87); wr(BASE, 8'h87); idle();
        chk(64'(cfg_mode), 64'd1, "R2 reopen");
        rd(BASE, 8'h61, "R5 index retained");
        idle();
        chk(64'(exp_q.size()), 64'd0, "scoreboard drained");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule